// File: doc/BRIEF.md
# DTMF Steering Guard Validator

This block sits behind a dual-tone detector and turns its raw "tone seen" flag into a debounced digit-valid flag. A digit is declared valid only after the raw flag has stayed high for a qualification period. Once valid, the digit stays valid until the raw flag has stayed low for a release period, so a short dropout inside one keypress does not split it into two digits. The 4-bit code is captured when the valid flag rises and is held until the next rise. A power-down input forces the valid flag low.

Both guard periods are parameters given in clock cycles. The defaults are 125829 cycles each, which is about 30 ms at a 4.194304 MHz clock. That value sits between the 20 ms reject limit and the 40 ms accept limit, both for tone length and for inter-digit gap. The raw flag is asynchronous to the clock and passes through a synchroniser of `SYNC_STAGES` flops (default 2) before it reaches the timers. Every latency below assumes `SYNC_STAGES` = 2.

Top module: `dtmf_guard_validator`

## Requirements
- R1: While `rst_i` is sampled high, `digit_valid_o` is 0 and `digit_o` is 0 from the next edge on.
- R2: With `digit_valid_o` low and power-down low, `digit_valid_o` rises on the clock edge two edges after the `PRESENT_CYC`-th consecutive edge on which `tone_raw_i` is sampled high. A run of `PRESENT_CYC`-1 high samples produces no rise.
- R3: A single low sample of `tone_raw_i` during qualification restarts the count, so the rise then needs a fresh run of `PRESENT_CYC` high samples.
- R4: With `digit_valid_o` high, it falls on the edge two edges after the `ABSENT_CYC`-th consecutive low sample of `tone_raw_i`. This holds even when the tone returns right after exactly `ABSENT_CYC` low samples. In that case the flag then rises again on the normal qualification schedule.
- R5: A dropout of `ABSENT_CYC`-1 low samples while `digit_valid_o` is high leaves it high, and the release count starts over once the tone returns.
- R6: `digit_o` loads the value of `digit_i` sampled on the edge where `digit_valid_o` rises. At all other edges it keeps its value, even if `digit_i` changes while the digit is valid.
- R7: `digit_valid_o` is low on every edge after one that samples `pwdn_i` high. After `pwdn_i` returns low with the tone still present, the flag rises on the `PRESENT_CYC`-th edge that samples `pwdn_i` low, and the digit is captured again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous active-high reset |
| pwdn_i | input | 1 | Power-down; forces the valid flag low and clears both timers |
| tone_raw_i | input | 1 | Raw tone-present flag from the detector, asynchronous |
| digit_i | input | DIGIT_W | Decoded digit code from the detector |
| digit_valid_o | output | 1 | Guard-time validated digit-present flag |
| digit_o | output | DIGIT_W | Code latched on the rising edge of the valid flag |

## Verification
A rise is due at edge s+`PRESENT_CYC`+2, where s is the edge just before the first high sample of the tone. A fall is due at e+`ABSENT_CYC`+2, where e is the edge just before the first low sample. After power-down is released at edge c, the flag rises at c+`PRESENT_CYC`; while power-down is high, the flag drops one edge after it is sampled. The driver logs the edge number whenever it changes an input. From that it computes each due edge and queues it. The monitor samples on the falling clock edge, pops an entry for each transition of the valid flag, and compares the exact edge number, level and latched code. Any transition with no queued entry, and any code change outside a rise, counts as a failure.

// File: rtl/dtmf_guard_pkg.sv
package dtmf_guard_pkg;

    typedef enum logic {
        STEER_IDLE   = 1'b0,
        STEER_ACTIVE = 1'b1
    } steer_state_e;

    // Bits needed for a counter that walks 0 .. limit-1
    function automatic int guard_cnt_w(input int limit);
        return (limit < 2) ? 1 : $clog2(limit);
    endfunction

endpackage

// File: rtl/dtmf_tone_sync.sv
module dtmf_tone_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk_i) begin
                    if (rst_i) chain[0] <= 1'b0;
                    else       chain[0] <= d_i;
                end
            end else begin : g_rest
                always_ff @(posedge clk_i) begin
                    if (rst_i) chain[g] <= 1'b0;
                    else       chain[g] <= chain[g-1];
                end
            end
        end
    endgenerate

    assign q_o = chain[STAGES-1];
endmodule

// File: rtl/dtmf_guard_timer.sv
module dtmf_guard_timer
    import dtmf_guard_pkg::*;
#(
    parameter int LIMIT = 125829
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic run_i,
    output logic expire_o
);
    localparam int CW = guard_cnt_w(LIMIT);
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt;

    // Fires in the cycle where the LIMIT-th consecutive run cycle is seen
    assign expire_o = run_i && (cnt == LAST);

    always_ff @(posedge clk_i) begin
        if (rst_i || !run_i || expire_o) cnt <= '0;
        else                             cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/dtmf_steer_ctrl.sv
module dtmf_steer_ctrl
    import dtmf_guard_pkg::*;
#(
    parameter int DIGIT_W = 4
) (
    input  logic               clk_i,
    input  logic               rst_i,
    input  logic               pwdn_i,
    input  logic               present_done_i,
    input  logic               absent_done_i,
    input  logic [DIGIT_W-1:0] digit_i,
    output steer_state_e       state_o,
    output logic [DIGIT_W-1:0] digit_o
);
    steer_state_e       state_q;
    logic [DIGIT_W-1:0] digit_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            state_q <= STEER_IDLE;
            digit_q <= '0;
        end else if (pwdn_i) begin
            state_q <= STEER_IDLE;
        end else begin
            unique case (state_q)
                STEER_IDLE: if (present_done_i) begin
                    state_q <= STEER_ACTIVE;
                    digit_q <= digit_i;
                end
                STEER_ACTIVE: if (absent_done_i) begin
                    state_q <= STEER_IDLE;
                end
                default: state_q <= STEER_IDLE;
            endcase
        end
    end

    assign state_o = state_q;
    assign digit_o = digit_q;
endmodule

// File: rtl/dtmf_guard_validator.sv
module dtmf_guard_validator
    import dtmf_guard_pkg::*;
#(
    parameter int DIGIT_W     = 4,
    parameter int SYNC_STAGES = 2,
    parameter int PRESENT_CYC = 125829,
    parameter int ABSENT_CYC  = 125829
) (
    input  logic               clk_i,
    input  logic               rst_i,
    input  logic               pwdn_i,
    input  logic               tone_raw_i,
    input  logic [DIGIT_W-1:0] digit_i,
    output logic               digit_valid_o,
    output logic [DIGIT_W-1:0] digit_o
);
    logic         tone_sync;
    logic         run_present;
    logic         run_absent;
    logic         present_done;
    logic         absent_done;
    steer_state_e state;

    dtmf_tone_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .d_i   (tone_raw_i),
        .q_o   (tone_sync)
    );

    assign run_present = tone_sync  && (state == STEER_IDLE)   && !pwdn_i;
    assign run_absent  = !tone_sync && (state == STEER_ACTIVE) && !pwdn_i;

    dtmf_guard_timer #(.LIMIT(PRESENT_CYC)) u_present_tmr (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .run_i    (run_present),
        .expire_o (present_done)
    );

    dtmf_guard_timer #(.LIMIT(ABSENT_CYC)) u_absent_tmr (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .run_i    (run_absent),
        .expire_o (absent_done)
    );

    dtmf_steer_ctrl #(.DIGIT_W(DIGIT_W)) u_ctrl (
        .clk_i          (clk_i),
        .rst_i          (rst_i),
        .pwdn_i         (pwdn_i),
        .present_done_i (present_done),
        .absent_done_i  (absent_done),
        .digit_i        (digit_i),
        .state_o        (state),
        .digit_o        (digit_o)
    );

    assign digit_valid_o = (state == STEER_ACTIVE);
endmodule

// File: rtl/dtmf_guard_validator_chk.sv
module dtmf_guard_validator_chk #(
    parameter int DIGIT_W = 4
) (
    input logic               clk_i,
    input logic               rst_i,
    input logic               pwdn_i,
    input logic               tone_sync,
    input logic [DIGIT_W-1:0] digit_i,
    input logic               digit_valid_o,
    input logic [DIGIT_W-1:0] digit_o
);
    // R7
    pwdn_forces_low_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        pwdn_i |=> !digit_valid_o);

    // R2
    rise_needs_tone_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(digit_valid_o) |-> $past(tone_sync) && !$past(pwdn_i));

    // R4
    fall_has_cause_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        $fell(digit_valid_o) |-> (!$past(tone_sync) || $past(pwdn_i) || $past(rst_i)));

    // R6
    digit_capture_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(digit_valid_o) |-> (digit_o == $past(digit_i)));

    // R6
    digit_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (!$rose(digit_valid_o) && !$past(rst_i)) |-> $stable(digit_o));
endmodule

bind dtmf_guard_validator dtmf_guard_validator_chk #(.DIGIT_W(DIGIT_W)) u_chk (
    .clk_i         (clk_i),
    .rst_i         (rst_i),
    .pwdn_i        (pwdn_i),
    .tone_sync     (tone_sync),
    .digit_i       (digit_i),
    .digit_valid_o (digit_valid_o),
    .digit_o       (digit_o)
);

// File: tb/dtmf_guard_validator_bench.sv
`timescale 1ns/1ps
module dtmf_guard_validator_bench;
    localparam int P  = 12;
    localparam int A  = 8;
    localparam int DW = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          pwdn = 1'b0;
    logic          tone = 1'b0;
    logic [DW-1:0] din = '0;
    logic          valid;
    logic [DW-1:0] dout;

    int cyc = 0;
    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    typedef struct {
        int            at;
        bit            lvl;
        logic [DW-1:0] code;
        string         req;
    } ev_t;
    ev_t expq[$];

    dtmf_guard_validator #(
        .DIGIT_W(DW), .SYNC_STAGES(2), .PRESENT_CYC(P), .ABSENT_CYC(A)
    ) u_dtmf_guard_validator (
        .clk_i(clk), .rst_i(rst), .pwdn_i(pwdn), .tone_raw_i(tone),
        .digit_i(din), .digit_valid_o(valid), .digit_o(dout)
    );

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic push(input int at, input bit lvl, input logic [DW-1:0] code, input string req);
        ev_t e;
        e.at = at; e.lvl = lvl; e.code = code; e.req = req;
        expq.push_back(e);
    endtask

    task automatic set_tone(input bit v, output int at);
        @(negedge clk);
        tone = v;
        at = cyc;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // Monitor: pops one expected event per transition of the valid flag
    bit            prev_v = 1'b0;
    logic [DW-1:0] prev_d = '0;
    always @(negedge clk) begin
        if (!rst) begin
            if (valid !== prev_v) begin
                if (expq.size() == 0) begin
                    check(1'b0, "R2/R4 unexpected transition", int'(valid), int'(prev_v));
                end else begin
                    ev_t e;
                    e = expq.pop_front();
                    check(valid === e.lvl, {e.req, " level"}, int'(valid), int'(e.lvl));
                    check(cyc == e.at, {e.req, " edge"}, cyc, e.at);
                    if (e.lvl)
                        check(dout === e.code, "R6 captured code", int'(dout), int'(e.code));
                end
            end
            if ((dout !== prev_d) && !(valid && !prev_v))
                check(1'b0, "R6 code changed outside rise", int'(dout), int'(prev_d));
        end
        prev_v = valid;
        prev_d = dout;
    end

    // Watchdog
    initial begin
        wait (cyc >= 20000 || done);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 20000);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int s, e, r, e2, c;
        idle(3);
        // R1: reset state
        check(valid === 1'b0, "R1 valid in reset", int'(valid), 0);
        check(dout === '0, "R1 code in reset", int'(dout), 0);
        @(negedge clk); rst = 1'b0;
        idle(4);
        check(valid === 1'b0, "R1 valid after reset", int'(valid), 0);

        // R2: P-1 samples rejected
        din = 4'd2;
        set_tone(1, s); idle(P - 2); set_tone(0, e);
        idle(A + 10);
        check(valid === 1'b0, "R2 short burst rejected", int'(valid), 0);

        // R2/R4: exactly P samples accepted, then normal release
        din = 4'd5;
        set_tone(1, s); push(s + P + 2, 1, 4'd5, "R2 rise");
        idle(P - 1); set_tone(0, e); push(e + A + 2, 0, '0, "R4 fall");
        idle(A + 10);
        check(dout === 4'd5, "R6 code held after fall", int'(dout), 5);

        // R3: glitch during qualification restarts the count
        din = 4'd1;
        set_tone(1, s); idle(7); set_tone(0, e);
        set_tone(1, r); push(r + P + 2, 1, 4'd1, "R3 restarted rise");
        idle(P + 3); set_tone(0, e2); push(e2 + A + 2, 0, '0, "R3 fall");
        idle(A + 10);

        // R5: dropout of A-1 samples is bridged
        din = 4'd9;
        set_tone(1, s); push(s + P + 2, 1, 4'd9, "R5 rise");
        idle(19); set_tone(0, e);
        idle(A - 2); set_tone(1, r);
        idle(9);
        check(valid === 1'b1, "R5 held through dropout", int'(valid), 1);
        set_tone(0, e2); push(e2 + A + 2, 0, '0, "R5 fall after full gap");
        idle(A + 10);

        // R4: gap of exactly A samples ends the digit, then requalify
        din = 4'd11;
        set_tone(1, s); push(s + P + 2, 1, 4'd11, "R4 first rise");
        idle(P + 5); set_tone(0, e); push(e + A + 2, 0, '0, "R4 exact gap fall");
        idle(A - 1); din = 4'd14; set_tone(1, r); push(r + P + 2, 1, 4'd14, "R4 requalify rise");
        idle(P + 5); set_tone(0, e2); push(e2 + A + 2, 0, '0, "R4 final fall");
        idle(A + 10);

        // R6: code change while valid is ignored
        din = 4'd3;
        set_tone(1, s); push(s + P + 2, 1, 4'd3, "R6 rise");
        idle(P + 5); din = 4'd12; idle(5);
        check(dout === 4'd3, "R6 hold while valid", int'(dout), 3);
        set_tone(0, e); push(e + A + 2, 0, '0, "R6 fall");
        idle(A + 10);
        set_tone(1, s); push(s + P + 2, 1, 4'd12, "R6 next capture");
        idle(P + 3); set_tone(0, e); push(e + A + 2, 0, '0, "R6 next fall");
        idle(A + 10);

        // R7: power-down forces low, then full requalification
        din = 4'd4;
        set_tone(1, s); push(s + P + 2, 1, 4'd4, "R7 rise");
        idle(P + 5);
        @(negedge clk); pwdn = 1'b1; c = cyc; push(c + 1, 0, '0, "R7 forced low");
        din = 4'd7;
        idle(P + 20);
        check(valid === 1'b0, "R7 low during power-down", int'(valid), 0);
        @(negedge clk); pwdn = 1'b0; c = cyc; push(c + P, 1, 4'd7, "R7 rise after release");
        idle(P + 5); set_tone(0, e); push(e + A + 2, 0, '0, "R7 final fall");
        idle(A + 10);

        check(expq.size() == 0, "R2/R4 pending events", expq.size(), 0);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule